// File: doc/BRIEF.md
# Serial Clock and Chip-Select Timer

This block paces one transfer of a serial peripheral master. It does not shift data. It tells a separate shift engine when the serial clock rises and when it falls. Around those edges it frames the transfer with a chip-select window: a setup time before the first edge, a hold time after the last edge, and a minimum idle gap before the next transfer. Each attached device has one 32-bit timing word in a table. The requester names a device, and the block uses that device's word for the transfer.

The bit rate comes from a fractional accumulator. Each cycle it adds the rate field, so the serial clock runs at the system clock times rate/512. Power-of-two rates from 1 to 128 give periods from 512 cycles down to 4 cycles. A rate of zero, or a rate above 128, is out of range. The block clamps it and reports a configuration error for that transfer. The shift engine raises `end_of_data` when the bit now being clocked is the last one. The active phase then ends on the next falling edge.

The start request is a valid/ready handshake. The requester raises `req_valid` with `req_dev` and holds both stable until `req_ready` is seen high at a rising clock edge. `req_ready` is high only while the block is idle, so a request made during a transfer or its trailing gap waits. The timing word is captured at the accepting edge.

Top module: `sclk_cs_timer`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only in the idle phase. The word of device `req_dev` is captured at acceptance, and later changes to `param_table` do not affect that transfer.
- R2: Device d owns bits [32d+31:32d] of `param_table`. Within that word, bits 31:24 are the rate, 23:16 the setup count, 15:8 the hold count and 7:0 the gap count.
- R3: With effective rate B, the edge strobes come every 256/B cycles. Strobes alternate, starting with `lead_stb`. The first `lead_stb` comes 256/B cycles after the active phase begins.
- R4: A rate of 0 is used as 1, and a rate above 128 is used as 128. Either case drives `cfg_err` high from the cycle after acceptance until the next acceptance. For a rate from 1 to 128, `cfg_err` is low.
- R5: The setup phase lasts max(S,1) cycles, with chip select asserted, before the active phase begins.
- R6: The active phase ends at the first trailing edge at which `end_of_data` is high. For an N-bit transfer it gives N lead strobes and N trailing strobes, and lasts 2·N·256/B cycles.
- R7: The hold phase lasts max(H,1) cycles with chip select asserted. The final `trail_stb` appears in its first cycle.
- R8: The gap phase lasts max(D,1) cycles with chip select deasserted. The block then returns to idle.
- R9: `phase` encodes idle=0, setup=1, active=2, hold=3, gap=4. `cs_active` is high in setup, active and hold, and low otherwise.
- R10: After reset the block is idle and ready. Chip select, both strobes, `sclk_level` and `cfg_err` are low.
- R11: The two strobes never coincide, and no strobe follows another on the next cycle. The serial clock is therefore never faster than a quarter of the system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start request |
| req_ready | output | 1 | Block is idle and will accept a request |
| req_dev | input | 3 | Device index for the request |
| param_table | input | 256 | Timing words of all devices, device 0 in the low bits |
| end_of_data | input | 1 | Bit being clocked is the last one |
| sclk_level | output | 1 | Serial clock level, low at rest |
| lead_stb | output | 1 | One-cycle pulse: serial clock has just risen |
| trail_stb | output | 1 | One-cycle pulse: serial clock has just fallen |
| cs_active | output | 1 | Chip select asserted |
| phase | output | 3 | Current phase code |
| cfg_err | output | 1 | Rate field of the current transfer was out of range |

## Verification
The embedded properties check the following on every cycle:
- The strobe pair is exclusive and spaced at least two cycles apart.
- Strobes occur only in the active phase, apart from the final falling edge.
- Phases follow the order setup, active, hold, gap, idle.
- Chip select rises only after an accepted request.
- `cfg_err` changes only at acceptance.

The bench scenarios cover what properties cannot express in simple form:
- The exact length of each phase, for many setup, hold and gap values.
- The strobe spacing and bit count for every legal power-of-two rate, and for the clamped rates.
- Selection of the right device word.
- That a table change made mid-transfer has no effect.

// File: rtl/sct_pkg.sv
package sct_pkg;
  localparam int FIELD_W  = 8;
  localparam int WORD_W   = 4 * FIELD_W;
  localparam int ACC_W    = FIELD_W + 1;
  localparam int RATE_MAX = 1 << (FIELD_W - 1);

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_ACTIVE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_GAP    = 3'd4
  } phase_e;

  typedef struct packed {
    logic [FIELD_W-1:0] rate;
    logic [FIELD_W-1:0] setup;
    logic [FIELD_W-1:0] hold;
    logic [FIELD_W-1:0] gap;
  } dev_cfg_t;

  function automatic dev_cfg_t split_word(input logic [WORD_W-1:0] w);
    dev_cfg_t c;
    c.rate  = w[4*FIELD_W-1 -: FIELD_W];
    c.setup = w[3*FIELD_W-1 -: FIELD_W];
    c.hold  = w[2*FIELD_W-1 -: FIELD_W];
    c.gap   = w[FIELD_W-1   -: FIELD_W];
    return c;
  endfunction
endpackage

// File: rtl/sct_param_select.sv
module sct_param_select
  import sct_pkg::*;
#(
  parameter int NUM_DEV = 8,
  localparam int DEV_W  = $clog2(NUM_DEV)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      accept,
  input  logic [DEV_W-1:0]          dev,
  input  logic [NUM_DEV*WORD_W-1:0] table_flat,
  output dev_cfg_t                  cfg_now,
  output dev_cfg_t                  cfg_q,
  output logic                      err_q
);
  logic [WORD_W-1:0] words [NUM_DEV];
  dev_cfg_t          raw;
  logic              rate_zero;
  logic              rate_big;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_word
    assign words[g] = table_flat[g*WORD_W +: WORD_W];
  end

  always_comb begin
    raw       = split_word(words[dev]);
    rate_zero = (raw.rate == '0);
    rate_big  = (raw.rate > FIELD_W'(RATE_MAX));
    cfg_now   = raw;
    if (rate_zero)     cfg_now.rate = FIELD_W'(1);
    else if (rate_big) cfg_now.rate = FIELD_W'(RATE_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      err_q <= 1'b0;
    end else if (accept) begin
      cfg_q <= cfg_now;
      err_q <= rate_zero | rate_big;
    end
  end

  AST_ERR_ONLY_AT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(err_q)); // R4
endmodule

// File: rtl/sct_rate_gen.sv
module sct_rate_gen
  import sct_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               eod,
  input  logic [FIELD_W-1:0] rate,
  output logic               sclk_lvl,
  output logic               lead_stb,
  output logic               trail_stb,
  output logic               last_edge
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] inc;
  logic [ACC_W:0]   sum;
  logic             carry;

  // doubled increment: a carry every 256/rate cycles marks one half period
  assign inc       = {rate, 1'b0};
  assign sum       = {1'b0, acc} + {1'b0, inc};
  assign carry     = sum[ACC_W];
  assign last_edge = run & carry & sclk_lvl & eod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      sclk_lvl  <= 1'b0;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else if (!run) begin
      acc       <= '0;
      sclk_lvl  <= 1'b0;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else begin
      acc       <= sum[ACC_W-1:0];
      lead_stb  <= carry & ~sclk_lvl;
      trail_stb <= carry & sclk_lvl;
      if (carry) sclk_lvl <= ~sclk_lvl;
    end
  end

  AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_stb && trail_stb)); // R11
  AST_STB_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_stb || trail_stb) |=> !(lead_stb || trail_stb)); // R11
endmodule

// File: rtl/sct_phase_ctrl.sv
module sct_phase_ctrl
  import sct_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic [FIELD_W-1:0] setup_now,
  input  logic [FIELD_W-1:0] hold_q,
  input  logic [FIELD_W-1:0] gap_q,
  input  logic               last_edge,
  output phase_e             phase
);
  logic [FIELD_W-1:0] cnt;
  logic               cnt_last;

  assign cnt_last = (cnt <= FIELD_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE:
          if (accept) begin
            phase <= PH_SETUP;
            cnt   <= setup_now;
          end
        PH_SETUP:
          if (cnt_last) phase <= PH_ACTIVE;
          else          cnt   <= cnt - 1'b1;
        PH_ACTIVE:
          if (last_edge) begin
            phase <= PH_HOLD;
            cnt   <= hold_q;
          end
        PH_HOLD:
          if (cnt_last) begin
            phase <= PH_GAP;
            cnt   <= gap_q;
          end else begin
            cnt <= cnt - 1'b1;
          end
        PH_GAP:
          if (cnt_last) phase <= PH_IDLE;
          else          cnt   <= cnt - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_SETUP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SETUP) |=> (phase == PH_SETUP || phase == PH_ACTIVE)); // R5
  AST_HOLD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HOLD) |=> (phase == PH_HOLD || phase == PH_GAP)); // R7
  AST_GAP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_GAP) |=> (phase == PH_GAP || phase == PH_IDLE)); // R8
  AST_ACTIVE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ACTIVE) |=> (phase == PH_ACTIVE || phase == PH_HOLD)); // R6
endmodule

// File: rtl/sclk_cs_timer.sv
module sclk_cs_timer
  import sct_pkg::*;
#(
  parameter int NUM_DEV = 8,
  localparam int DEV_W  = $clog2(NUM_DEV)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [DEV_W-1:0]          req_dev,
  input  logic [NUM_DEV*WORD_W-1:0] param_table,
  input  logic                      end_of_data,
  output logic                      sclk_level,
  output logic                      lead_stb,
  output logic                      trail_stb,
  output logic                      cs_active,
  output logic [2:0]                phase,
  output logic                      cfg_err
);
  phase_e   ph;
  dev_cfg_t cfg_now;
  dev_cfg_t cfg_q;
  logic     accept;
  logic     run;
  logic     last_edge;

  assign req_ready = (ph == PH_IDLE);
  assign accept    = req_valid & req_ready;
  assign run       = (ph == PH_ACTIVE);
  assign cs_active = (ph == PH_SETUP) | (ph == PH_ACTIVE) | (ph == PH_HOLD);
  assign phase     = ph;

  sct_param_select #(.NUM_DEV(NUM_DEV)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .dev       (req_dev),
    .table_flat(param_table),
    .cfg_now   (cfg_now),
    .cfg_q     (cfg_q),
    .err_q     (cfg_err)
  );

  sct_rate_gen u_rate (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .eod      (end_of_data),
    .rate     (cfg_q.rate),
    .sclk_lvl (sclk_level),
    .lead_stb (lead_stb),
    .trail_stb(trail_stb),
    .last_edge(last_edge)
  );

  sct_phase_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .setup_now(cfg_now.setup),
    .hold_q   (cfg_q.hold),
    .gap_q    (cfg_q.gap),
    .last_edge(last_edge),
    .phase    (ph)
  );

  AST_CS_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_active) |-> $past(accept)); // R1
  AST_LEAD_IN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |-> (ph == PH_ACTIVE)); // R3
  AST_TRAIL_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
    trail_stb |-> (ph == PH_ACTIVE || ph == PH_HOLD)); // R7
endmodule

// File: tb/sclk_cs_timer_test.sv
module sclk_cs_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NDEV       = 8;
  localparam int WATCHDOG   = 150000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [2:0]   req_dev = '0;
  logic [255:0] param_table = '0;
  logic         end_of_data = 1'b0;
  logic         sclk_level, lead_stb, trail_stb, cs_active, cfg_err;
  logic [2:0]   phase;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sclk_cs_timer #(.NUM_DEV(NDEV)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dev(req_dev), .param_table(param_table), .end_of_data(end_of_data),
    .sclk_level(sclk_level), .lead_stb(lead_stb), .trail_stb(trail_stb),
    .cs_active(cs_active), .phase(phase), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_word(input int dev, input int rate, input int s, input int h, input int d);
    param_table[dev*32 +: 32] = {rate[7:0], s[7:0], h[7:0], d[7:0]};
  endtask

  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  // runs one transfer on a device whose word is already loaded
  task automatic run_xfer(input int dev, input int nbits, input int rate,
                          input int s, input int h, input int d, input bit scramble);
    int eff, half, es, eh, ed, exp_err;
    int idx, setup_c, active_c, hold_c, gap_c, cs_c, ready_bad;
    int leads, trails, first_lead, last_stb, spacing_bad, err_seen;
    bit timed_out;
    eff = (rate == 0) ? 1 : (rate > 128) ? 128 : rate;
    exp_err = (rate == 0 || rate > 128) ? 1 : 0;
    half = 256 / eff;
    es = at_least_one(s); eh = at_least_one(h); ed = at_least_one(d);
    idx = 0; setup_c = 0; active_c = 0; hold_c = 0; gap_c = 0; cs_c = 0;
    ready_bad = 0; leads = 0; trails = 0; first_lead = -1; last_stb = -1;
    spacing_bad = 0; err_seen = 0; timed_out = 0;

    @(negedge clk);
    req_dev     = dev[2:0];
    req_valid   = 1'b1;
    end_of_data = (nbits <= 1);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (scramble) set_word(dev, 128, 9, 9, 9);
    err_seen = cfg_err;
    while (phase != 3'd0) begin
      case (phase)
        3'd1: setup_c++;
        3'd2: active_c++;
        3'd3: hold_c++;
        3'd4: gap_c++;
        default: ;
      endcase
      if (cs_active) cs_c++;
      if (req_ready) ready_bad++;
      if (lead_stb) begin
        leads++;
        if (first_lead < 0) first_lead = idx;
      end
      if (trail_stb) trails++;
      if (lead_stb || trail_stb) begin
        if (last_stb >= 0 && (idx - last_stb) != half) spacing_bad++;
        last_stb = idx;
      end
      end_of_data = (trails >= nbits - 1);
      idx++;
      if (idx > 20000) begin
        timed_out = 1;
        break;
      end
      @(negedge clk);
    end
    end_of_data = 1'b0;
    check(!timed_out, "R6 transfer completes", idx, 0);
    check(setup_c == es, "R5 setup cycles", setup_c, es);
    check(active_c == 2*nbits*half, "R6 active cycles", active_c, 2*nbits*half);
    check(leads == nbits, "R6 lead strobes", leads, nbits);
    check(trails == nbits, "R6 trail strobes", trails, nbits);
    check(hold_c == eh, "R7 hold cycles", hold_c, eh);
    check(gap_c == ed, "R8 gap cycles", gap_c, ed);
    check(cs_c == es + 2*nbits*half + eh, "R9 chip select cycles", cs_c, es + 2*nbits*half + eh);
    check(spacing_bad == 0, "R3 strobe spacing", spacing_bad, 0);
    check(first_lead == es + half, "R3 first lead position", first_lead, es + half);
    check(err_seen == exp_err, "R4 cfg_err", err_seen, exp_err);
    check(ready_bad == 0, "R1 ready low while busy", ready_bad, 0);
    check(req_ready == 1'b1, "R8 ready after gap", int'(req_ready), 1);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int rates [11];
    rates = '{0, 1, 2, 4, 8, 16, 32, 64, 128, 200, 255};
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(phase == 3'd0, "R10 phase idle", int'(phase), 0);
    check(req_ready == 1'b1, "R10 ready", int'(req_ready), 1);
    check(cs_active == 1'b0, "R10 chip select", int'(cs_active), 0);
    check(!lead_stb && !trail_stb, "R10 strobes", int'(lead_stb) + int'(trail_stb), 0);
    check(sclk_level == 1'b0, "R10 sclk level", int'(sclk_level), 0);
    check(cfg_err == 1'b0, "R10 cfg_err", int'(cfg_err), 0);

    // rate sweep incl. clamped values (R3, R4, R5-R8 timing)
    foreach (rates[i]) begin
      int dev, nb, s, h, d;
      dev = i % NDEV; nb = 1 + (i % 3); s = i % 4; h = (i + 1) % 4; d = (i + 2) % 5;
      set_word(dev, rates[i], s, h, d);
      run_xfer(dev, nb, rates[i], s, h, d, 1'b0);
    end

    // R2 device selection: every word distinct, loaded before any transfer
    for (int dv = 0; dv < NDEV; dv++)
      set_word(dv, 1 << (dv % 8), dv + 2, 7 - dv, (dv * 3) % 6);
    for (int dv = NDEV - 1; dv >= 0; dv--) begin
      if ((1 << (dv % 8)) >= 8)
        run_xfer(dv, 2, 1 << (dv % 8), dv + 2, 7 - dv, (dv * 3) % 6, 1'b0);
    end

    // R1 table change after acceptance has no effect
    set_word(5, 32, 4, 2, 3);
    run_xfer(5, 3, 32, 4, 2, 3, 1'b1);
    set_word(2, 0, 1, 1, 1);
    run_xfer(2, 1, 0, 1, 1, 1, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule